// File: doc/BRIEF.md
# Debug Port Authentication Gate

This block sits between a scan-chain debug transport and the register access path of an on-chip debug unit. Out of reset the path is closed: every debug request is answered with an error and zero read data, and nothing is forwarded downstream. To open it, the user shifts in a 64-bit password as two 32-bit beats. The gate hands the password to an external keyed-hash engine through a start/done handshake. It then compares the returned 256-bit digest against an expected value fixed at build time.

The comparison runs chunk by chunk for a fixed number of cycles. It ORs together the XOR differences of every chunk and never leaves early, so its duration reveals nothing about where a mismatch lies. On a match, the gate first pulses a clear strobe that scrubs the secret registers it guards, and only then opens the path. On a mismatch, it pulses an error and counts the failure. Once seven failures have been counted, password entry is refused until reset. A blown-fuse input closes the path at once and keeps any attempt from starting. A relock input closes the path again.

Top module: `dbg_auth_gate`

## Requirements
- R1: After reset the gate is locked. While locked, each request (`req_valid`=1) gives `rsp_valid`=1, `rsp_err`=1 and `rsp_rdata`=0, and `down_valid` stays 0.
- R2: A password is accepted as two `pw_valid` beats: the first beat fills bits 31:0, the second fills bits 63:32. In the cycle after the second beat, `hash_start` is high for exactly one cycle and `hash_msg` equals the password.
- R3: After the start pulse the gate waits for `hash_done` for as long as it takes, and the gate stays locked while it waits. The digest is taken from `hash_digest` in the cycle where `hash_done` is high.
- R4: The comparison takes exactly DIG_W/CMP_W cycles (4 by default) after the `hash_done` cycle, whatever the data and wherever the first differing bit lies.
- R5: On a match, `secret_clear` is high for exactly one cycle, and access opens in the cycle after it.
- R6: When open, `req_valid`, `req_write`, `req_addr` and `req_wdata` appear unchanged on the `down_*` outputs in the same cycle, `rsp_rdata` equals `down_rdata`, and `rsp_err`=0.
- R7: On a mismatch, `auth_fail` is high for exactly one cycle, `secret_clear` stays low, and the gate is locked again.
- R8: A 3-bit failure count rises with every mismatch, is not cleared by a later success, and saturates at 7. Once it reaches 7, password beats are ignored (no `hash_start`) until reset.
- R9: `relock` high at a clock edge returns the gate to locked from any state. A digest that arrives after an aborted attempt does not open access.
- R10: While `fuse_blown` is high, requests are refused in the same cycle, password beats start no hash, and no state change can open access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fuse_blown | input | 1 | Permanent debug disable |
| relock | input | 1 | Return to locked |
| pw_valid | input | 1 | Password beat strobe |
| pw_data | input | 32 | Password beat |
| hash_start | output | 1 | Start pulse to hash engine |
| hash_msg | output | 64 | Password presented to hash engine |
| hash_done | input | 1 | Hash engine finished |
| hash_digest | input | 256 | Digest from hash engine |
| secret_clear | output | 1 | Scrub strobe for guarded secrets |
| auth_fail | output | 1 | Mismatch pulse |
| req_valid | input | 1 | Debug request valid |
| req_write | input | 1 | Debug request is a write |
| req_addr | input | 7 | Debug register address |
| req_wdata | input | 32 | Debug write data |
| rsp_valid | output | 1 | Response valid |
| rsp_err | output | 1 | Request refused |
| rsp_rdata | output | 32 | Response read data |
| down_valid | output | 1 | Forwarded request valid |
| down_write | output | 1 | Forwarded write flag |
| down_addr | output | 7 | Forwarded address |
| down_wdata | output | 32 | Forwarded write data |
| down_rdata | input | 32 | Read data from debug registers |

## Verification
The bench feeds digests that differ from the expected one only in bit 0, only in bit 255, or in every bit. It checks that the verdict arrives after the same number of cycles each time; an early-exit comparator would finish sooner for the low-bit case. It drives seven failures and then a correct password, which a counter that wraps or is not checked would let through. It raises relock while the hash is still running and then delivers a matching digest late, which a gate that ignores the abort would use to unlock. It also raises the fuse on an open gate, and a gate that only registered the fuse would leak one request.

// File: rtl/dbg_auth_pkg.sv
package dbg_auth_pkg;
    typedef enum logic [2:0] {
        ST_LOCKED = 3'd0,
        ST_PW_HI  = 3'd1,
        ST_HASH   = 3'd2,
        ST_CMP    = 3'd3,
        ST_CLEAR  = 3'd4,
        ST_OPEN   = 3'd5
    } auth_st_e;
endpackage

// File: rtl/dbg_auth_cmp.sv
// Selects one digest chunk and reports whether it differs from the expected one.
module dbg_auth_cmp #(
    parameter int DIG_W = 256,
    parameter int CMP_W = 64,
    localparam int N_CHUNK = DIG_W / CMP_W,
    localparam int IDX_W = (N_CHUNK > 1) ? $clog2(N_CHUNK) : 1
) (
    input  logic [DIG_W-1:0] digest,
    input  logic [DIG_W-1:0] expected,
    input  logic [IDX_W-1:0] idx,
    output logic             chunk_diff
);
    logic [CMP_W-1:0] xor_chunk [N_CHUNK];

    for (genvar g = 0; g < N_CHUNK; g++) begin : g_chunk
        assign xor_chunk[g] = digest[g*CMP_W +: CMP_W] ^ expected[g*CMP_W +: CMP_W];
    end

    assign chunk_diff = |xor_chunk[idx];
endmodule

// File: rtl/dbg_auth_port.sv
// Access gate: forwards requests when open, refuses them otherwise.
module dbg_auth_port #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input  logic              open,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] down_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              down_valid,
    output logic              down_write,
    output logic [ADDR_W-1:0] down_addr,
    output logic [DATA_W-1:0] down_wdata
);
    always_comb begin
        rsp_valid  = req_valid;
        rsp_err    = req_valid && !open;
        down_valid = req_valid && open;
        down_write = open ? req_write : 1'b0;
        down_addr  = open ? req_addr  : '0;
        down_wdata = open ? req_wdata : '0;
        rsp_rdata  = (req_valid && open) ? down_rdata : '0;
    end
endmodule

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate
    import dbg_auth_pkg::*;
#(
    parameter int BEAT_W = 32,
    parameter int DIG_W  = 256,
    parameter int CMP_W  = 64,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32,
    parameter int FAIL_W = 3,
    parameter logic [DIG_W-1:0] EXP_DIGEST = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fuse_blown,
    input  logic                relock,
    input  logic                pw_valid,
    input  logic [BEAT_W-1:0]   pw_data,
    output logic                hash_start,
    output logic [2*BEAT_W-1:0] hash_msg,
    input  logic                hash_done,
    input  logic [DIG_W-1:0]    hash_digest,
    output logic                secret_clear,
    output logic                auth_fail,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                down_valid,
    output logic                down_write,
    output logic [ADDR_W-1:0]   down_addr,
    output logic [DATA_W-1:0]   down_wdata,
    input  logic [DATA_W-1:0]   down_rdata
);
    localparam int N_CHUNK  = DIG_W / CMP_W;
    localparam int IDX_W    = (N_CHUNK > 1) ? $clog2(N_CHUNK) : 1;
    localparam int PW_W     = 2 * BEAT_W;
    localparam logic [FAIL_W-1:0] FAIL_MAX = '1;
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(N_CHUNK - 1);

    typedef struct packed {
        auth_st_e          st;
        logic [PW_W-1:0]   msg;
        logic [DIG_W-1:0]  dig;
        logic [IDX_W-1:0]  idx;
        logic              diff;
        logic [FAIL_W-1:0] fails;
        logic              start;
        logic              fail_p;
    } gate_regs_t;

    gate_regs_t r_d, r_q;
    auth_st_e   state_q;
    logic       chunk_diff;
    logic       lockout;
    logic       open;

    dbg_auth_cmp #(.DIG_W(DIG_W), .CMP_W(CMP_W)) u_cmp (
        .digest     (r_q.dig),
        .expected   (EXP_DIGEST),
        .idx        (r_q.idx),
        .chunk_diff (chunk_diff)
    );

    assign lockout = (r_q.fails == FAIL_MAX);

    always_comb begin
        r_d        = r_q;
        r_d.start  = 1'b0;
        r_d.fail_p = 1'b0;
        unique case (r_q.st)
            ST_LOCKED: begin
                if (pw_valid && !lockout) begin
                    r_d.msg[BEAT_W-1:0] = pw_data;
                    r_d.st              = ST_PW_HI;
                end
            end
            ST_PW_HI: begin
                if (pw_valid) begin
                    r_d.msg[PW_W-1:BEAT_W] = pw_data;
                    r_d.start              = 1'b1;
                    r_d.st                 = ST_HASH;
                end
            end
            ST_HASH: begin
                if (hash_done) begin
                    r_d.dig  = hash_digest;
                    r_d.idx  = '0;
                    r_d.diff = 1'b0;
                    r_d.st   = ST_CMP;
                end
            end
            ST_CMP: begin
                // every chunk is visited; the verdict waits for the last one
                r_d.diff = r_q.diff | chunk_diff;
                r_d.idx  = r_q.idx + 1'b1;
                if (r_q.idx == IDX_LAST) begin
                    if (r_d.diff) begin
                        r_d.st     = ST_LOCKED;
                        r_d.fail_p = 1'b1;
                        if (!lockout) r_d.fails = r_q.fails + 1'b1;
                    end else begin
                        r_d.st = ST_CLEAR;
                    end
                end
            end
            ST_CLEAR: r_d.st = ST_OPEN;
            ST_OPEN:  r_d.st = ST_OPEN;
            default:  r_d.st = ST_LOCKED;
        endcase
        if (relock || fuse_blown) begin
            r_d.st    = ST_LOCKED;
            r_d.start = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_q      = r_q.st;
    assign hash_start   = r_q.start;
    assign hash_msg     = r_q.msg;
    assign secret_clear = (r_q.st == ST_CLEAR);
    assign auth_fail    = r_q.fail_p;
    assign open         = (r_q.st == ST_OPEN) && !fuse_blown;

    dbg_auth_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .open       (open),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .down_rdata (down_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata),
        .down_valid (down_valid),
        .down_write (down_write),
        .down_addr  (down_addr),
        .down_wdata (down_wdata)
    );
endmodule

// File: rtl/dbg_auth_gate_chk.sv
module dbg_auth_gate_chk
    import dbg_auth_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int N_CHUNK = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fuse_blown,
    input logic              relock,
    input logic              req_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              down_valid,
    input logic              hash_start,
    input logic              hash_done,
    input logic              secret_clear,
    input logic              auth_fail,
    input auth_st_e          st
);
    logic [7:0] cmp_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cmp_run <= '0;
        else if (st == ST_CMP)  cmp_run <= cmp_run + 8'd1;
        else                    cmp_run <= '0;
    end

    p_refuse_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (req_valid && !down_valid && rsp_rdata == '0));

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hash_start |=> !hash_start);

    p_hold_for_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HASH && !hash_done && !relock && !fuse_blown) |=> (st == ST_HASH));

    p_cmp_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CMP) |-> (cmp_run < 8'(N_CHUNK)));

    p_cmp_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_CMP && $past(st) == ST_CMP && !$past(relock) && !$past(fuse_blown))
        |-> ($past(cmp_run) == 8'(N_CHUNK - 1)));

    p_clear_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OPEN && $past(st) != ST_OPEN) |-> $past(secret_clear));

    p_fail_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        auth_fail |-> (!secret_clear && st != ST_OPEN));

    p_fuse_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_blown |-> !down_valid);
endmodule

bind dbg_auth_gate dbg_auth_gate_chk #(.DATA_W(DATA_W), .N_CHUNK(N_CHUNK)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fuse_blown   (fuse_blown),
    .relock       (relock),
    .req_valid    (req_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata),
    .down_valid   (down_valid),
    .hash_start   (hash_start),
    .hash_done    (hash_done),
    .secret_clear (secret_clear),
    .auth_fail    (auth_fail),
    .st           (state_q)
);

// File: tb/sim_dbg_auth_gate.sv
module sim_dbg_auth_gate;
    localparam int CLK_PERIOD = 10;
    localparam int CMP_CYC    = 4;
    localparam logic [63:0]  GOOD_PW  = 64'hC0FFEE11_5EC0DE42;
    localparam logic [63:0]  BAD_PW   = 64'h0BADF00D_12345678;
    localparam logic [255:0] GOOD_DIG =
        256'h9A3F_17C2_5E88_0D41_B6E2_4C90_731A_F05D_2B7E_C913_46A8_DD05_E1F4_3879_0C6B_A25E;

    typedef struct packed {
        logic [63:0]  pw;
        logic [255:0] dig;
        logic         ok;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{pw: GOOD_PW, dig: GOOD_DIG,                      ok: 1'b1},
        '{pw: BAD_PW,  dig: GOOD_DIG ^ 256'd1,             ok: 1'b0},
        '{pw: GOOD_PW, dig: GOOD_DIG,                      ok: 1'b1},
        '{pw: BAD_PW,  dig: GOOD_DIG ^ {1'b1, 255'd0},     ok: 1'b0},
        '{pw: 64'd0,   dig: ~GOOD_DIG,                     ok: 1'b0},
        '{pw: GOOD_PW, dig: GOOD_DIG,                      ok: 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fuse_blown = 1'b0;
    logic         relock = 1'b0;
    logic         pw_valid = 1'b0;
    logic [31:0]  pw_data = '0;
    logic         hash_start;
    logic [63:0]  hash_msg;
    logic         hash_done = 1'b0;
    logic [255:0] hash_digest = '0;
    logic         secret_clear;
    logic         auth_fail;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [6:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         rsp_valid;
    logic         rsp_err;
    logic [31:0]  rsp_rdata;
    logic         down_valid;
    logic         down_write;
    logic [6:0]   down_addr;
    logic [31:0]  down_wdata;
    logic [31:0]  down_rdata;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign down_rdata = {25'h1A5A5A5, down_addr} ^ 32'h0000_0F0F;

    dbg_auth_gate #(.EXP_DIGEST(GOOD_DIG)) u0 (
        .clk(clk), .rst_n(rst_n), .fuse_blown(fuse_blown), .relock(relock),
        .pw_valid(pw_valid), .pw_data(pw_data),
        .hash_start(hash_start), .hash_msg(hash_msg),
        .hash_done(hash_done), .hash_digest(hash_digest),
        .secret_clear(secret_clear), .auth_fail(auth_fail),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .down_valid(down_valid), .down_write(down_write),
        .down_addr(down_addr), .down_wdata(down_wdata), .down_rdata(down_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fuse_blown = 1'b0; relock = 1'b0; pw_valid = 1'b0; hash_done = 1'b0; req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_req(input bit exp_open, input logic [6:0] a, input string tag);
        logic [31:0] wd;
        logic [31:0] rd;
        wd = {a, 25'h0123457};
        rd = {25'h1A5A5A5, a} ^ 32'h0000_0F0F;
        @(negedge clk);
        req_valid = 1'b1; req_write = a[0]; req_addr = a; req_wdata = wd;
        #1;
        if (exp_open) begin
            chk(down_valid && down_addr == a && down_wdata == wd && down_write == a[0] && rsp_valid,
                tag, {down_valid, down_addr}, {1'b1, a});
            chk(!rsp_err && rsp_rdata == rd, tag, {rsp_err, rsp_rdata}, {1'b0, rd});
        end else begin
            chk(!down_valid && rsp_valid && rsp_err && rsp_rdata == '0, tag,
                {down_valid, rsp_err, rsp_rdata}, {2'b01, 32'd0});
        end
        req_valid = 1'b0;
    endtask

    task automatic send_pw(input logic [63:0] pw);
        @(negedge clk); pw_valid = 1'b1; pw_data = pw[31:0];
        @(negedge clk); pw_data = pw[63:32];
        @(negedge clk); pw_valid = 1'b0;
    endtask

    task automatic attempt(input logic [63:0] pw, input logic [255:0] dig, input bit exp_ok);
        int cyc;
        send_pw(pw);
        chk(hash_start && hash_msg == pw, "R2 start/msg", hash_msg, pw);
        do_req(1'b0, 7'h11, "R3 locked while hashing");
        chk(!hash_start, "R2 single pulse", 64'(hash_start), 64'd0);
        repeat (3) @(negedge clk);
        chk(!secret_clear && !auth_fail, "R3 waits for done", {secret_clear, auth_fail}, 64'd0);
        hash_done = 1'b1; hash_digest = dig;
        @(negedge clk);
        hash_done = 1'b0; hash_digest = '0;
        cyc = 0;
        while (!(secret_clear || auth_fail) && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == CMP_CYC, "R4 compare length", 64'(cyc), 64'(CMP_CYC));
        if (exp_ok) begin
            chk(secret_clear && !auth_fail, "R5 clear on match", {secret_clear, auth_fail}, 64'b10);
            do_req(1'b1, 7'h2B, "R6 open pass-through");
            chk(!secret_clear, "R5 clear one cycle", 64'(secret_clear), 64'd0);
            do_req(1'b1, 7'h40, "R6 open read");
        end else begin
            chk(auth_fail && !secret_clear, "R7 fail pulse", {secret_clear, auth_fail}, 64'b01);
            do_req(1'b0, 7'h05, "R7 locked after fail");
            chk(!auth_fail, "R7 fail one cycle", 64'(auth_fail), 64'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R1 act=timeout exp=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        @(negedge clk);
        chk(!hash_start && !secret_clear && !auth_fail, "R1 reset outputs",
            {hash_start, secret_clear, auth_fail}, 64'd0);
        do_req(1'b0, 7'h01, "R1 refused after reset");

        // vector table
        for (int i = 0; i < 6; i++) begin
            attempt(VECS[i].pw, VECS[i].dig, VECS[i].ok);
            if (VECS[i].ok) begin
                @(negedge clk); relock = 1'b1;
                @(negedge clk); relock = 1'b0;
                do_req(1'b0, 7'h22, "R9 relock from open");
            end
        end

        // R9: abort during hash, late matching digest must not open
        send_pw(GOOD_PW);
        relock = 1'b1;
        @(negedge clk); relock = 1'b0;
        hash_done = 1'b1; hash_digest = GOOD_DIG;
        @(negedge clk); hash_done = 1'b0;
        repeat (6) @(negedge clk);
        chk(!secret_clear, "R9 no clear after abort", 64'(secret_clear), 64'd0);
        do_req(1'b0, 7'h33, "R9 still locked after abort");

        // R10: fuse closes an open gate in the same cycle and blocks attempts
        do_reset();
        attempt(GOOD_PW, GOOD_DIG, 1'b1);
        @(negedge clk); fuse_blown = 1'b1;
        #1;
        req_valid = 1'b1; req_addr = 7'h44; #1;
        chk(!down_valid && rsp_err, "R10 fuse refuses at once", {down_valid, rsp_err}, 64'b01);
        req_valid = 1'b0;
        send_pw(GOOD_PW);
        chk(!hash_start, "R10 no start when fused", 64'(hash_start), 64'd0);
        repeat (8) @(negedge clk);
        do_req(1'b0, 7'h45, "R10 stays locked");

        // R8: seven failures lock out entry until reset
        do_reset();
        for (int k = 0; k < 7; k++) attempt(BAD_PW, ~GOOD_DIG, 1'b0);
        send_pw(GOOD_PW);
        chk(!hash_start, "R8 entry ignored at 7", 64'(hash_start), 64'd0);
        repeat (8) @(negedge clk);
        do_req(1'b0, 7'h50, "R8 locked out");
        do_reset();
        attempt(GOOD_PW, GOOD_DIG, 1'b1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule